// File: doc/BRIEF.md
# Named Two-Line Context Cache

This block keeps up to two saved task contexts close to the logic that uses them. Each line is tagged by an 8-bit context name and holds an opaque bit vector, as wide as the largest context. The cache is fully associative and is looked up by name, not by address. A requester issues one order per accepted cycle: store a context, fetch a context, drop a context, or fetch and drop it in one step. When a new name must be stored and both lines are taken, the least recently used line is pushed out to global memory over a valid/ready port. The new context is written only after that transfer completes.

The control is a two-state machine. In `ST_IDLE` the block accepts orders (`req_ready` high). An order is decoded into one of `ORD_NONE`, `ORD_WRITE`, `ORD_READ`, `ORD_READ_DIS` or `ORD_DISABLE`. The transition `ST_IDLE -> ST_EVICT` is taken only by a write whose name misses while both lines are valid. The transition `ST_EVICT -> ST_IDLE` is taken on the cycle where `ev_ready` meets `ev_valid`, and that same edge stores the pending context into the freed line. Every other order completes in `ST_IDLE` in a single cycle.

Top module: `ctx_cache`

## Requirements
- R1: After reset both lines are invalid, `req_ready` is 1, and `ev_valid`, `rd_valid` and `rd_miss` are 0. A read issued right after reset misses.
- R2: A write whose name misses while some line is invalid stores the context in an invalid line without any eviction. `req_ready` stays 1.
- R3: A write whose name matches a valid line replaces that line's data in place, with no eviction. No two valid lines ever carry the same name.
- R4: A read (`req_rd`=1, `req_wr`=0, `req_dis`=0) of a stored name raises `rd_valid` for exactly one cycle, starting at the clock edge after the order is accepted. `rd_data` holds the stored bits during that cycle.
- R5: A read of a name that is not stored raises `rd_miss` for exactly one cycle, at the same point as R4. `rd_valid` stays 0. `rd_valid` and `rd_miss` are never high together.
- R6: A write that misses while both lines are valid raises `ev_valid` on the next cycle. It presents the name and data of the least recently used line, holds them stable until `ev_ready`, and keeps `req_ready` at 0 meanwhile.
- R7: At the edge where `ev_valid` and `ev_ready` are both 1, the new context replaces the evicted line and the block returns to accepting orders. Afterwards the new name hits and the evicted name misses.
- R8: A disable order (`req_dis`=1, `req_rd`=0, `req_wr`=0) clears the line whose name matches. Later reads of that name miss, and the freed line is reused by the next write miss without eviction.
- R9: A read-and-disable order (`req_rd`=1 and `req_dis`=1, `req_wr`=0) returns the data as in R4 and invalidates the line, so a following read of that name misses.
- R10: If `req_wr` is 1 together with `req_rd` and/or `req_dis`, only the write is performed. Neither `rd_valid` nor `rd_miss` responds, and no line is invalidated.
- R11: Read hits, write hits, allocations and completed evictions each make the touched line the most recently used. The victim in R6 is always the other line.
- R12: A disable order for a name that is not stored changes nothing: both stored contexts stay readable with their data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write order bit |
| req_rd | input | 1 | Read order bit |
| req_dis | input | 1 | Disable order bit (with `req_rd`: read-and-disable) |
| req_name | input | NAME_W | Context name of the order |
| req_wdata | input | DATA_W | Context bits for a write |
| req_ready | output | 1 | Orders are accepted on edges where this is 1 |
| rd_valid | output | 1 | One-cycle read hit strobe |
| rd_miss | output | 1 | One-cycle read miss strobe |
| rd_data | output | DATA_W | Context bits returned on a read hit |
| ev_valid | output | 1 | Eviction transfer pending |
| ev_ready | input | 1 | Global memory accepts the evicted line |
| ev_name | output | NAME_W | Name of the evicted context |
| ev_data | output | DATA_W | Bits of the evicted context |

## Verification
Two functions can share a cycle. One pair is a write and a read raised together on the order inputs. The other is the completion of an eviction handshake and the recency update it makes on the line it refills. The bench drives `req_wr` together with `req_rd` and `req_dis` on both hit and miss names. It judges the result by the absence of any read response and by later reads that show the write landed and nothing was dropped. Evictions are provoked by writing fresh names with both lines full. `ev_ready` is held off for zero to three random cycles. A bench-side recency model predicts which name must leave, and later reads confirm which names survive.

// File: rtl/ctx_cache_pkg.sv
package ctx_cache_pkg;

    typedef enum logic [2:0] {
        ORD_NONE,
        ORD_WRITE,
        ORD_READ,
        ORD_READ_DIS,
        ORD_DISABLE
    } order_e;

    typedef enum logic {
        ST_IDLE,
        ST_EVICT
    } state_e;

endpackage

// File: rtl/ctx_tag_match.sv
module ctx_tag_match #(
    parameter int LINES  = 2,
    parameter int NAME_W = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [LINES-1:0]             vld,
    input  logic [LINES-1:0][NAME_W-1:0] names,
    input  logic [NAME_W-1:0]            key,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = vld[g] && (names[g] == key);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ctx_lru.sv
module ctx_lru #(
    parameter int LINES  = 2,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] vld,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx,
    output logic             full
);

    // With two lines the least recently used line is simply the one
    // not touched last; a single bit records it.
    logic [IDX_W-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch) begin
            lru_q <= ~touch_idx;
        end
    end

    always_comb begin
        full       = &vld;
        victim_idx = lru_q;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!vld[i]) victim_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ctx_cache.sv
module ctx_cache
    import ctx_cache_pkg::*;
#(
    parameter int NAME_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic              req_dis,
    input  logic [NAME_W-1:0] req_name,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic              rd_miss,
    output logic [DATA_W-1:0] rd_data,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [NAME_W-1:0] ev_name,
    output logic [DATA_W-1:0] ev_data
);

    localparam int LINES = 2;
    localparam int IDX_W = 1;

    state_e state_q, state_d;
    order_e ord;

    logic [LINES-1:0]             line_vld;
    logic [LINES-1:0][NAME_W-1:0] line_name;
    logic [LINES-1:0][DATA_W-1:0] line_data;

    logic              hit, full, touch, take;
    logic [IDX_W-1:0]  hit_idx, victim_idx, touch_idx;
    logic [IDX_W-1:0]  pend_idx;
    logic [NAME_W-1:0] pend_name;
    logic [DATA_W-1:0] pend_data;

    ctx_tag_match #(.LINES(LINES), .NAME_W(NAME_W)) u_match (
        .vld     (line_vld),
        .names   (line_name),
        .key     (req_name),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    ctx_lru #(.LINES(LINES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld        (line_vld),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx),
        .full       (full)
    );

    // Order decode: a write wins over any read or disable bit.
    always_comb begin
        if (req_wr)                 ord = ORD_WRITE;
        else if (req_rd && req_dis) ord = ORD_READ_DIS;
        else if (req_rd)            ord = ORD_READ;
        else if (req_dis)           ord = ORD_DISABLE;
        else                        ord = ORD_NONE;
    end

    assign take      = (state_q == ST_IDLE);
    assign req_ready = take;
    assign ev_valid  = (state_q == ST_EVICT);
    assign ev_name   = line_name[pend_idx];
    assign ev_data   = line_data[pend_idx];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ord == ORD_WRITE && !hit && full) state_d = ST_EVICT;
            ST_EVICT: if (ev_ready)                         state_d = ST_IDLE;
        endcase
    end

    // Recency update
    always_comb begin
        touch     = 1'b0;
        touch_idx = hit_idx;
        if (state_q == ST_EVICT) begin
            touch     = ev_ready;
            touch_idx = pend_idx;
        end else begin
            unique case (ord)
                ORD_WRITE: begin
                    touch     = hit || !full;
                    touch_idx = hit ? hit_idx : victim_idx;
                end
                ORD_READ, ORD_READ_DIS: touch = hit;
                ORD_NONE, ORD_DISABLE:  touch = 1'b0;
            endcase
        end
    end

    // Line storage and pending write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_vld  <= '0;
            line_name <= '0;
            line_data <= '0;
            pend_idx  <= '0;
            pend_name <= '0;
            pend_data <= '0;
        end else if (state_q == ST_IDLE) begin
            if (ord == ORD_WRITE) begin
                if (hit) begin
                    line_data[hit_idx] <= req_wdata;
                end else if (!full) begin
                    line_vld[victim_idx]  <= 1'b1;
                    line_name[victim_idx] <= req_name;
                    line_data[victim_idx] <= req_wdata;
                end else begin
                    pend_idx  <= victim_idx;
                    pend_name <= req_name;
                    pend_data <= req_wdata;
                end
            end else if ((ord == ORD_READ_DIS || ord == ORD_DISABLE) && hit) begin
                line_vld[hit_idx] <= 1'b0;
            end
        end else if (ev_ready) begin
            line_name[pend_idx] <= pend_name;
            line_data[pend_idx] <= pend_data;
        end
    end

    // Read response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_miss  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take && (ord == ORD_READ || ord == ORD_READ_DIS) && hit;
            rd_miss  <= take && (ord == ORD_READ || ord == ORD_READ_DIS) && !hit;
            if (take && hit) rd_data <= line_data[hit_idx];
        end
    end

    // Checks next to the logic they guard
    assert_ev_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_name) && $stable(ev_data));

    assert_ev_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_valid) |-> $past(req_wr));

    assert_ev_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_ready |=> req_ready && !ev_valid);

    assert_resp_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_miss));

    assert_unique_names_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_vld[0] && line_vld[1] && line_name[0] == line_name[1]));

    assert_wr_over_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_wr |=> !rd_valid && !rd_miss);

endmodule

// File: tb/tb_ctx_cache.sv
module tb_ctx_cache;

    localparam int CLK_P  = 10;
    localparam int NAME_W = 8;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_wr = 1'b0, req_rd = 1'b0, req_dis = 1'b0;
    logic [NAME_W-1:0] req_name = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, rd_valid, rd_miss, ev_valid;
    logic              ev_ready = 1'b0;
    logic [DATA_W-1:0] rd_data, ev_data;
    logic [NAME_W-1:0] ev_name;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the two lines and their recency
    bit                m_v[2];
    logic [NAME_W-1:0] m_n[2];
    logic [DATA_W-1:0] m_d[2];
    int                m_lru = 0;

    always #(CLK_P/2) clk = ~clk;

    ctx_cache #(.NAME_W(NAME_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_wr(req_wr), .req_rd(req_rd), .req_dis(req_dis),
        .req_name(req_name), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_miss(rd_miss), .rd_data(rd_data),
        .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_name(ev_name), .ev_data(ev_data)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic int model_find(input logic [NAME_W-1:0] nm);
        int r = -1;
        for (int i = 0; i < 2; i++) if (m_v[i] && m_n[i] == nm) r = i;
        return r;
    endfunction

    function automatic int model_free();
        int r = -1;
        for (int i = 1; i >= 0; i--) if (!m_v[i]) r = i;
        return r;
    endfunction

    task automatic op(input bit w, input bit r, input bit d,
                      input logic [NAME_W-1:0] nm, input logic [DATA_W-1:0] dat,
                      input string tag);
        int hi, fr, vic, dly;
        logic [NAME_W-1:0] en;
        logic [DATA_W-1:0] ed;
        hi = model_find(nm);
        @(negedge clk);
        req_wr = w; req_rd = r; req_dis = d; req_name = nm; req_wdata = dat;
        @(posedge clk);
        @(negedge clk);
        req_wr = 0; req_rd = 0; req_dis = 0;
        if (w) begin
            chk(!rd_valid && !rd_miss, {tag, " R10 no read response on write"},
                {62'd0, rd_valid, rd_miss}, '0);
            if (hi >= 0) begin
                m_d[hi] = dat; m_lru = 1 - hi;
                chk(!ev_valid && req_ready, {tag, " R3 hit write no evict"}, ev_valid, 0);
            end else begin
                fr = model_free();
                if (fr >= 0) begin
                    m_v[fr] = 1; m_n[fr] = nm; m_d[fr] = dat; m_lru = 1 - fr;
                    chk(!ev_valid && req_ready, {tag, " R2 alloc no evict"}, ev_valid, 0);
                end else begin
                    vic = m_lru; en = m_n[vic]; ed = m_d[vic];
                    chk(ev_valid && !req_ready, {tag, " R6 eviction raised"}, ev_valid, 1);
                    chk(ev_name == en, {tag, " R11 victim name"}, ev_name, en);
                    chk(ev_data == ed, {tag, " R6 victim data"}, ev_data, ed);
                    dly = $urandom_range(0, 3);
                    for (int k = 0; k < dly; k++) begin
                        @(negedge clk);
                        chk(ev_valid && !req_ready && ev_name == en && ev_data == ed,
                            {tag, " R6 eviction held"}, ev_data, ed);
                    end
                    ev_ready = 1;
                    @(posedge clk);
                    @(negedge clk);
                    ev_ready = 0;
                    chk(!ev_valid && req_ready, {tag, " R7 handshake done"}, ev_valid, 0);
                    m_n[vic] = nm; m_d[vic] = dat; m_lru = 1 - vic;
                end
            end
        end else if (r) begin
            if (hi >= 0) begin
                chk(rd_valid && !rd_miss && rd_data == m_d[hi],
                    {tag, " R4 read hit data"}, rd_data, m_d[hi]);
                m_lru = 1 - hi;
                if (d) m_v[hi] = 0;
            end else begin
                chk(rd_miss && !rd_valid, {tag, " R5 read miss"},
                    {62'd0, rd_valid, rd_miss}, 64'd1);
            end
            @(negedge clk);
            chk(!rd_valid && !rd_miss, {tag, " R5 strobe lasts one cycle"},
                {62'd0, rd_valid, rd_miss}, '0);
        end else if (d) begin
            chk(!rd_valid && !rd_miss && !ev_valid, {tag, " R8 disable quiet"},
                {61'd0, ev_valid, rd_valid, rd_miss}, '0);
            if (hi >= 0) m_v[hi] = 0;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_v[0] = 0; m_v[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !ev_valid && !rd_valid && !rd_miss, "R1 reset outputs",
            {60'd0, req_ready, ev_valid, rd_valid, rd_miss}, 64'h8);
        op(0, 1, 0, 8'h10, '0, "R1");
        op(1, 0, 0, 8'h11, 64'hA1, "R2");
        op(1, 0, 0, 8'h22, 64'hB2, "R2");
        op(0, 1, 0, 8'h11, '0, "R4");
        op(1, 0, 0, 8'h11, 64'hC3, "R3");
        op(0, 1, 0, 8'h11, '0, "R3");
        op(1, 0, 0, 8'h33, 64'hD4, "R6");
        op(0, 1, 0, 8'h33, '0, "R7");
        op(0, 1, 0, 8'h22, '0, "R7");
        op(0, 1, 0, 8'h11, '0, "R11");
        op(1, 0, 0, 8'h33, 64'hE5, "R11");
        op(1, 0, 0, 8'h44, 64'hF6, "R11");
        op(0, 1, 0, 8'h11, '0, "R11");
        op(0, 0, 1, 8'h99, '0, "R12");
        op(0, 1, 0, 8'h33, '0, "R12");
        op(0, 1, 0, 8'h44, '0, "R12");
        op(0, 0, 1, 8'h33, '0, "R8");
        op(0, 1, 0, 8'h33, '0, "R8");
        op(1, 0, 0, 8'h55, 64'h77, "R8");
        op(0, 1, 1, 8'h44, '0, "R9");
        op(0, 1, 0, 8'h44, '0, "R9");
        op(1, 1, 0, 8'h55, 64'h1234, "R10");
        op(1, 1, 1, 8'h66, 64'h5678, "R10");
        op(0, 1, 0, 8'h55, '0, "R10");
        op(0, 1, 0, 8'h66, '0, "R10");
        for (int i = 0; i < 400; i++) begin
            logic [NAME_W-1:0] nm;
            logic [DATA_W-1:0] dt;
            int kind;
            nm   = 8'h40 + NAME_W'($urandom_range(0, 3));
            dt   = {$urandom, $urandom};
            kind = $urandom_range(0, 5);
            case (kind)
                0, 1: op(1, 0, 0, nm, dt, "RND R2 R3 R6");
                2:    op(0, 1, 0, nm, dt, "RND R4 R5");
                3:    op(0, 1, 1, nm, dt, "RND R9");
                4:    op(0, 0, 1, nm, dt, "RND R8");
                default: op(1, 1, ($urandom_range(0, 1) == 1), nm, dt, "RND R10");
            endcase
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule